// File: doc/BRIEF.md
# Comparator Wakeup Deglitch and Event Controller

This block sits behind an analog wakeup comparator whose digital output arrives with no timing relation to the system clock. It passes that output through a synchroniser and samples it on a sample strobe at one of two rates. The slow rate is one strobe every `DIV_SLOW` clocks, which is 250 kHz from a 100 MHz clock. The fast rate is one strobe every `DIV_FAST` clocks, which is 2 MHz. A new comparator level is accepted only after it has held through a programmable number of consecutive samples. An accepted upward change latches a rising-event flag and an accepted downward change latches a falling-event flag.

Each flag has its own wakeup enable. The wakeup request is high while any enabled flag is set. Software uses a small single-cycle write bus with combinational read to set the controls and to clear flags. A 0 written to a flag bit clears that flag.

Filtering is done by a four-state machine:
- IDLE: the block is disabled.
- ARM: waiting for the first sample after enable.
- STEADY: the accepted level matches the input.
- QUALIFY: a differing level is being timed.

It has these transitions:
- *wake*: IDLE to ARM, once enabled.
- *seed*: ARM to STEADY, on the first sample.
- *doubt*: STEADY to QUALIFY, on a differing sample with a non-zero window.
- *accept*: to STEADY, when the window completes or is zero.
- *relapse*: QUALIFY to STEADY, on an agreeing sample.
- *halt*: any state to IDLE, on disable.

Top module: `cmp_wake_ctrl`

## Requirements
- R1: After reset the registers read as follows. Control reads 0, glitch reads 0, and event reads 0. Mask reads 0x820, meaning both enables are set. `wake_req` is low.
- R2: The register word addresses are fixed. Address 0 is control: bit 7 enables the block and bit 0 selects the fast sample rate. Address 1 is mask: bit 5 enables rising wakeups and bit 11 enables falling wakeups. Address 2 is event: bit 5 is the rising flag and bit 11 is the falling flag. Address 3 is glitch, a 3-bit setting in bits 2:0. All other read bits are 0.
- R3: While enabled, a sample strobe fires once every `DIV_SLOW` clocks when control bit 0 is 0, and once every `DIV_FAST` clocks when it is 1.
- R4: The window W is the glitch setting times 1 in slow mode, or times 8 in fast mode. A differing synchronised level is accepted only on its (W+1)th consecutive differing sample. Any agreeing sample before that discards the change.
- R5: With a glitch setting of 0, a level that differs at a single sample is accepted at that sample.
- R6: An accepted change from 0 to 1 sets event bit 5. An accepted change from 1 to 0 sets event bit 11.
- R7: On the first sample after enable, the input level is taken as the accepted level. If that level is 0, event bit 11 is set. If it is 1, no flag is set.
- R8: While control bit 7 is 0, input changes set no flag.
- R9: Writing the event register clears each flag whose data bit is 0. A flag whose data bit is 1 keeps its value.
- R10: If a flag is set by hardware in the same cycle that a write clears it, the flag ends up set.
- R11: `wake_req` = (bit5 flag AND mask bit 5) OR (bit11 flag AND mask bit 11). Once asserted, it stays high until a bus write changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Asynchronous comparator output |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| wake_req | output | 1 | Wakeup/interrupt request |

## Verification
Two things can fall in the same cycle: a hardware event set from an accepted transition, and a software write-0 clear of that same flag. The bench keeps a behavioural model that can predict the exact clock of the next acceptance. Using that prediction, it issues the clear write on precisely that clock. It then judges the result by reading the event register, which must still show the flag, and by checking that the request is still raised.

// File: rtl/cmp_wake_pkg.sv
package cmp_wake_pkg;

    typedef enum logic [1:0] {
        DG_IDLE    = 2'd0,
        DG_ARM     = 2'd1,
        DG_STEADY  = 2'd2,
        DG_QUALIFY = 2'd3
    } dg_state_e;

    localparam int unsigned ADDR_CTRL   = 0;
    localparam int unsigned ADDR_MASK   = 1;
    localparam int unsigned ADDR_EVT    = 2;
    localparam int unsigned ADDR_GLITCH = 3;

    localparam int unsigned BIT_FAST   = 0;
    localparam int unsigned BIT_ENABLE = 7;
    localparam int unsigned BIT_RISE   = 5;
    localparam int unsigned BIT_FALL   = 11;

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cmp_sample_tick.sv
module cmp_sample_tick #(
    parameter int unsigned DIV_SLOW = 400,
    parameter int unsigned DIV_FAST = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic tick
);
    localparam int unsigned DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int unsigned CW      = $clog2(DIV_MAX) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last = fast ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
    assign tick = run && (cnt_q >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (!run || cnt_q >= last) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (DIV_SLOW > 1 && DIV_FAST > 1) begin : g_gap_chk
            p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("sample strobes on adjacent clocks");
        end
    endgenerate
endmodule

// File: rtl/cmp_deglitch.sv
module cmp_deglitch
    import cmp_wake_pkg::*;
#(
    parameter int unsigned GL_W      = 3,
    parameter int unsigned FAST_MULT = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic            fast,
    input  logic            sig,
    input  logic [GL_W-1:0] glitch_sel,
    output logic            rise_p,
    output logic            fall_p
);
    localparam int unsigned NEED_MAX = ((1 << GL_W) - 1) * FAST_MULT;
    localparam int unsigned NW       = $clog2(NEED_MAX + 1) + 1;

    dg_state_e     st_q, st_d;
    logic          lvl_q, lvl_d;
    logic [NW-1:0] cnt_q, cnt_d;
    logic [NW-1:0] need;
    logic          differ;
    logic          take;
    logic          seed_low;

    assign need   = fast ? NW'(glitch_sel) * NW'(FAST_MULT) : NW'(glitch_sel);
    assign differ = (sig != lvl_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DG_IDLE;
            lvl_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            lvl_q <= lvl_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        lvl_d    = lvl_q;
        cnt_d    = cnt_q;
        take     = 1'b0;
        seed_low = 1'b0;
        if (!run) begin
            st_d  = DG_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                DG_IDLE: st_d = DG_ARM;
                DG_ARM: begin
                    if (tick) begin
                        lvl_d    = sig;
                        seed_low = !sig;
                        st_d     = DG_STEADY;
                    end
                end
                DG_STEADY: begin
                    if (tick && differ) begin
                        if (need == '0) begin
                            take = 1'b1;
                        end else begin
                            cnt_d = NW'(1);
                            st_d  = DG_QUALIFY;
                        end
                    end
                end
                DG_QUALIFY: begin
                    if (tick) begin
                        if (!differ) begin
                            cnt_d = '0;
                            st_d  = DG_STEADY;
                        end else if (cnt_q == need) begin
                            take = 1'b1;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: st_d = DG_IDLE;
            endcase
            if (take) begin
                lvl_d = !lvl_q;
                cnt_d = '0;
                st_d  = DG_STEADY;
            end
        end
    end

    always_comb begin
        rise_p = take && !lvl_q;
        fall_p = (take && lvl_q) || seed_low;
    end

    p_edge_on_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_p || fall_p) |-> tick)
        else $error("event outside a sample strobe");

    p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !(rise_p || fall_p))
        else $error("event while disabled");

    p_rise_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_p |=> lvl_q)
        else $error("rise did not leave level high");

    p_fall_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fall_p |=> !lvl_q)
        else $error("fall did not leave level low");
endmodule

// File: rtl/cmp_wake_ctrl.sv
module cmp_wake_ctrl
    import cmp_wake_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned DIV_SLOW    = 400,
    parameter int unsigned DIV_FAST    = 50,
    parameter int unsigned GL_W        = 3,
    parameter int unsigned FAST_MULT   = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_raw,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wake_req
);
    logic            en_q, fast_q;
    logic            ren_q, fen_q;
    logic            rflag_q, fflag_q;
    logic [GL_W-1:0] gl_q;
    logic            sig_s, tick, rise_p, fall_p;
    logic            wr_ctrl, wr_mask, wr_evt, wr_gl;

    assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(ADDR_CTRL));
    assign wr_mask = bus_we && (bus_addr == ADDR_W'(ADDR_MASK));
    assign wr_evt  = bus_we && (bus_addr == ADDR_W'(ADDR_EVT));
    assign wr_gl   = bus_we && (bus_addr == ADDR_W'(ADDR_GLITCH));

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(sig_s)
    );

    cmp_sample_tick #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(en_q), .fast(fast_q), .tick(tick)
    );

    cmp_deglitch #(.GL_W(GL_W), .FAST_MULT(FAST_MULT)) u_dg (
        .clk(clk), .rst_n(rst_n), .run(en_q), .tick(tick), .fast(fast_q),
        .sig(sig_s), .glitch_sel(gl_q), .rise_p(rise_p), .fall_p(fall_p)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            fast_q <= 1'b0;
            ren_q  <= 1'b1;
            fen_q  <= 1'b1;
            gl_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q   <= bus_wdata[BIT_ENABLE];
                fast_q <= bus_wdata[BIT_FAST];
            end
            if (wr_mask) begin
                ren_q <= bus_wdata[BIT_RISE];
                fen_q <= bus_wdata[BIT_FALL];
            end
            if (wr_gl) gl_q <= bus_wdata[GL_W-1:0];
        end
    end

    // hardware set is ORed after the clear so a coincident set survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rflag_q <= 1'b0;
            fflag_q <= 1'b0;
        end else begin
            rflag_q <= (wr_evt ? (rflag_q & bus_wdata[BIT_RISE]) : rflag_q) | rise_p;
            fflag_q <= (wr_evt ? (fflag_q & bus_wdata[BIT_FALL]) : fflag_q) | fall_p;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
            bus_rdata[BIT_ENABLE] = en_q;
            bus_rdata[BIT_FAST]   = fast_q;
        end else if (bus_addr == ADDR_W'(ADDR_MASK)) begin
            bus_rdata[BIT_RISE] = ren_q;
            bus_rdata[BIT_FALL] = fen_q;
        end else if (bus_addr == ADDR_W'(ADDR_EVT)) begin
            bus_rdata[BIT_RISE] = rflag_q;
            bus_rdata[BIT_FALL] = fflag_q;
        end else if (bus_addr == ADDR_W'(ADDR_GLITCH)) begin
            bus_rdata[GL_W-1:0] = gl_q;
        end
    end

    assign wake_req = (rflag_q && ren_q) || (fflag_q && fen_q);

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rflag_q && !wr_evt) |=> rflag_q)
        else $error("rising flag lost without a write");

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fall_p |=> fflag_q)
        else $error("falling set lost");

    p_set_wins_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise_p |=> rflag_q)
        else $error("rising set lost");

    p_wake_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !bus_we) |=> wake_req)
        else $error("wake request dropped without a write");
endmodule

// File: tb/cmp_wake_ctrl_bench.sv
module cmp_wake_ctrl_bench;
    localparam int DS = 16;
    localparam int DF = 2;
    localparam int A_CTRL = 0, A_MASK = 1, A_EVT = 2, A_GL = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_raw = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'(A_EVT);
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wake_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cmp_wake_ctrl #(.DIV_SLOW(DS), .DIV_FAST(DF)) u_cmp_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wake_req(wake_req)
    );

    // behavioural reference model
    bit m_s1, m_s2, m_en, m_fast, m_re, m_fe, m_rf, m_ff, m_lvl;
    int m_gl, m_tc, m_st, m_run;

    function automatic bit f_tick();
        int d = m_fast ? DF : DS;
        return m_en && (m_tc >= d - 1);
    endfunction

    function automatic int f_need();
        return m_gl * (m_fast ? 8 : 1);
    endfunction

    function automatic bit f_accept();
        if (!m_en || !f_tick() || (m_s2 == m_lvl)) return 0;
        if (m_st == 2) return f_need() == 0;
        if (m_st == 3) return m_run == f_need();
        return 0;
    endfunction

    function automatic logic [31:0] f_read(input int a);
        logic [31:0] r = '0;
        case (a)
            A_CTRL: begin r[7] = m_en; r[0] = m_fast; end
            A_MASK: begin r[5] = m_re; r[11] = m_fe; end
            A_EVT:  begin r[5] = m_rf; r[11] = m_ff; end
            default: r[2:0] = 3'(m_gl);
        endcase
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_en = 0; m_fast = 0; m_re = 1; m_fe = 1;
            m_rf = 0; m_ff = 0; m_lvl = 0; m_gl = 0; m_tc = 0; m_st = 0; m_run = 0;
        end else begin
            bit tk, acc, rs, fl;
            int dv;
            tk = f_tick(); acc = f_accept(); rs = 0; fl = 0;
            dv = m_fast ? DF : DS;
            if (!m_en) begin
                m_st = 0; m_run = 0;
            end else if (acc) begin
                m_lvl = !m_lvl; rs = m_lvl; fl = !m_lvl; m_st = 2; m_run = 0;
            end else begin
                case (m_st)
                    0: m_st = 1;
                    1: if (tk) begin m_lvl = m_s2; fl = !m_s2; m_st = 2; end
                    2: if (tk && m_s2 != m_lvl) begin m_run = 1; m_st = 3; end
                    default: if (tk) begin
                        if (m_s2 == m_lvl) begin m_st = 2; m_run = 0; end
                        else m_run++;
                    end
                endcase
            end
            if (!m_en || m_tc >= dv - 1) m_tc = 0; else m_tc++;
            m_s2 = m_s1; m_s1 = cmp_raw;
            if (bus_we) begin
                case (int'(bus_addr))
                    A_CTRL: begin m_en = bus_wdata[7]; m_fast = bus_wdata[0]; end
                    A_MASK: begin m_re = bus_wdata[5]; m_fe = bus_wdata[11]; end
                    A_EVT:  begin m_rf = m_rf & bus_wdata[5]; m_ff = m_ff & bus_wdata[11]; end
                    default: m_gl = int'(bus_wdata[2:0]);
                endcase
            end
            m_rf = m_rf | rs;
            m_ff = m_ff | fl;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison with the model, sampled mid low phase
    always @(negedge clk) begin
        #3;
        if (rst_n && !done) begin
            chk(wake_req == ((m_rf && m_re) || (m_ff && m_fe)), "R11 per-clock wake",
                32'(wake_req), 32'((m_rf && m_re) || (m_ff && m_fe)));
            chk(bus_rdata == f_read(int'(bus_addr)), "R2 per-clock read",
                bus_rdata, f_read(int'(bus_addr)));
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = 2'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 0; bus_addr = 2'(A_EVT);
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = 2'(a);
        #2;
        chk(bus_rdata == exp, req, bus_rdata, exp);
        bus_addr = 2'(A_EVT);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        // R1 reset state
        rd(A_CTRL, 32'h0, "R1 ctrl reset");
        rd(A_MASK, 32'h820, "R1 mask reset");
        rd(A_EVT, 32'h0, "R1 event reset");
        rd(A_GL, 32'h0, "R1 glitch reset");
        chk(wake_req == 0, "R1 wake reset", 32'(wake_req), 0);

        // R7 enable with input low, slow rate, no filter
        cmp_raw = 0;
        wr(A_CTRL, 32'h80);
        rd(A_CTRL, 32'h80, "R2 ctrl readback");
        idle(40);
        rd(A_EVT, 32'h800, "R7 falling on enable with low input");
        chk(wake_req == 1, "R11 wake on falling", 32'(wake_req), 1);
        wr(A_EVT, 32'hFFFF_FFFF);
        rd(A_EVT, 32'h800, "R9 write ones keeps flag");
        wr(A_EVT, ~(32'h1 << 11));
        rd(A_EVT, 32'h0, "R9 write zero clears flag");
        chk(wake_req == 0, "R11 wake drops after clear", 32'(wake_req), 0);

        // R4 slow window of 2 -> 3 samples; short pulse rejected
        wr(A_GL, 32'h2);
        rd(A_GL, 32'h2, "R2 glitch readback");
        cmp_raw = 1; idle(20); cmp_raw = 0;
        idle(100);
        rd(A_EVT, 32'h0, "R4 short pulse rejected (slow)");
        cmp_raw = 1; idle(80);
        rd(A_EVT, 32'h20, "R6 rising accepted after window");
        wr(A_EVT, 32'h0);

        // R5 zero window: a pulse spanning one sample is accepted both ways
        wr(A_GL, 32'h0);
        cmp_raw = 0; idle(20); cmp_raw = 1;
        idle(40);
        rd(A_EVT, 32'h820, "R5 zero window accepts short pulse");
        wr(A_EVT, 32'h0);

        // R3/R4 fast rate, setting 1 -> 8-sample window
        wr(A_CTRL, 32'h81);
        wr(A_GL, 32'h1);
        idle(10);
        cmp_raw = 0; idle(10); cmp_raw = 1;
        idle(40);
        rd(A_EVT, 32'h0, "R4 short pulse rejected (fast)");
        cmp_raw = 0; idle(60);
        rd(A_EVT, 32'h800, "R3 fast falling accepted");
        wr(A_EVT, 32'h0);

        // R11 masked rising still latches but no wakeup
        wr(A_MASK, 32'h800);
        cmp_raw = 1; idle(60);
        rd(A_EVT, 32'h20, "R6 rising latched while masked");
        chk(wake_req == 0, "R11 masked flag gives no wake", 32'(wake_req), 0);
        wr(A_MASK, 32'h820);
        chk(wake_req == 1, "R11 unmask raises wake", 32'(wake_req), 1);
        wr(A_EVT, 32'h0);

        // R8 disabled: changes ignored
        wr(A_CTRL, 32'h0);
        cmp_raw = 0; idle(80); cmp_raw = 1; idle(80); cmp_raw = 0; idle(80);
        rd(A_EVT, 32'h0, "R8 no events while disabled");
        cmp_raw = 1; idle(10);
        wr(A_CTRL, 32'h80);
        idle(60);
        rd(A_EVT, 32'h0, "R7 enable with high input gives no event");

        // R10 coincident set and clear
        cmp_raw = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (f_accept()) begin
                bus_we = 1; bus_addr = 2'(A_EVT); bus_wdata = 32'h0;
                @(negedge clk);
                bus_we = 0;
                break;
            end
        end
        rd(A_EVT, 32'h800, "R10 set wins over same-cycle clear");
        chk(wake_req == 1, "R10 wake after coincident set", 32'(wake_req), 1);

        idle(5);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule